// File: doc/BRIEF.md
# Migration Request Coalescing Queue

This block sits between the address-translation logic and the host link of a device memory manager that moves partial pages on demand. Each time a translation finds data missing from local memory, it hands this block a migration need made of a page number, the first missing unit inside the page and a unit count. The block turns the need into a bounded request. The start is pulled down to a minimum-length grain and the end is pushed out to at least one grain, so the link never carries tiny transfers. The request then waits in a small ordered queue.

Before a new need is stored, the pending requests behind the one currently offered to the link are searched. The oldest one for the same page whose range touches or overlaps the new range absorbs it, provided the combined range stays within a merge limit. Requests go out oldest first over a valid/ready handshake. When the host side reports that a transfer has finished, the matching request is retired and a one-cycle replay pulse with the page number tells the translation logic to retry its stalled accesses.

Top module: `migration_coalesce_queue`

## Requirements
- R1: An accepted need with page P, start S and count C is widened to the range [S rounded down to MIN_LEN, E), where E is min(S+C, 2^UNIT_W) raised to at least the rounded start plus MIN_LEN. Defaults: MIN_LEN 4 units, 32 units per page.
- R2: Every offered request has a length of at least MIN_LEN, a start that is a multiple of MIN_LEN, and an end not beyond the page end.
- R3: A widened need merges into the oldest pending entry behind the offered one that has the same page, a range that overlaps or abuts the new one (new start <= entry end and entry start <= new end), and a union no longer than MERGE_MAX (default 8). That entry's range becomes the union. Otherwise the need is appended.
- R4: An entry already sent to the link, or currently offered on the request port, is never merged into.
- R5: Requests are offered in arrival order. While req_valid is high and req_ready is low, page, start and length stay unchanged.
- R6: The queue holds DEPTH entries (default 8), and slots are freed in arrival order, one per cycle. need_ready is low only when the tail slot is occupied and no merge is possible. A mergeable need is accepted when the queue is full.
- R7: A completion whose page, start and length equal a sent entry retires that entry and, on the next cycle, raises replay_valid for one cycle with replay_page equal to the completed page. A completion that matches no sent entry produces no pulse.
- R8: A need accepted into an empty queue is offered on the request port in the cycle after its handshake.
- R9: After reset, req_valid and replay_valid are low and need_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_valid | input | 1 | Migration need present |
| need_ready | output | 1 | Need accepted this cycle when valid |
| need_page | input | PAGE_W | Page number of the need |
| need_start | input | UNIT_W | First missing unit in the page |
| need_count | input | UNIT_W+1 | Number of units requested |
| req_valid | output | 1 | Request offered to the host link |
| req_ready | input | 1 | Host link takes the request |
| req_page | output | PAGE_W | Page of offered request |
| req_start | output | UNIT_W | First unit of offered request |
| req_len | output | UNIT_W+1 | Length in units of offered request |
| cpl_valid | input | 1 | Transfer completion report |
| cpl_page | input | PAGE_W | Page of completed transfer |
| cpl_start | input | UNIT_W | Start unit of completed transfer |
| cpl_len | input | UNIT_W+1 | Length of completed transfer |
| replay_valid | output | 1 | One-cycle pulse to replay stalled translations |
| replay_page | output | PAGE_W | Page whose accesses may be replayed |

## Verification
On every cycle the assertions hold the offered request to the grain, alignment and page limits, keep it frozen while the link stalls, confirm that a merge result covers the need it absorbed, and require every replay pulse to follow a completion. Only the bench scenarios can show which entry a need joins, that sent or offered entries stay untouched, the exact stall point of a full queue, the arrival order of issue, and that a completion matching nothing raises no pulse. For these the bench compares a cycle-level reference queue against the ports under directed and random traffic.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_PEND = 2'd1,
    SL_SENT = 2'd2,
    SL_DONE = 2'd3
  } slot_st_e;
endpackage

// File: rtl/mcq_widen.sv
module mcq_widen #(
  parameter int UNIT_W  = 5,
  parameter int MIN_LEN = 4
) (
  input  logic [UNIT_W-1:0] in_start,
  input  logic [UNIT_W:0]   in_count,
  output logic [UNIT_W-1:0] out_start,
  output logic [UNIT_W:0]   out_end
);
  localparam int UNITS = 1 << UNIT_W;
  localparam logic [UNIT_W+1:0] PAGE_END   = (UNIT_W+2)'(UNITS);
  localparam logic [UNIT_W-1:0] ALIGN_MASK = ~(UNIT_W'(MIN_LEN - 1));

  logic [UNIT_W+1:0] raw_end;
  logic [UNIT_W+1:0] floor_end;
  logic [UNIT_W+1:0] clip_end;

  always_comb begin
    out_start = in_start & ALIGN_MASK;
    raw_end   = {2'b00, in_start} + {1'b0, in_count};
    floor_end = {2'b00, out_start} + (UNIT_W+2)'(MIN_LEN);
    clip_end  = (raw_end > PAGE_END) ? PAGE_END : raw_end;
    if (clip_end < floor_end) clip_end = floor_end;
    out_end = clip_end[UNIT_W:0];
  end

  // R1: widened range never leaves the page
  always_comb begin
    a_r1_in_page: assert ({1'b0, out_end} <= PAGE_END);
  end
endmodule

// File: rtl/mcq_merge_find.sv
module mcq_merge_find
  import mcq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PAGE_W    = 4,
  parameter int UNIT_W    = 5,
  parameter int MERGE_MAX = 8,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  slot_st_e [DEPTH-1:0]             slot_st,
  input  logic     [DEPTH-1:0][PAGE_W-1:0] slot_page,
  input  logic     [DEPTH-1:0][UNIT_W-1:0] slot_start,
  input  logic     [DEPTH-1:0][UNIT_W:0]   slot_end,
  input  logic     [PTR_W-1:0]             iss_ptr,
  input  logic     [PAGE_W-1:0]            new_page,
  input  logic     [UNIT_W-1:0]            new_start,
  input  logic     [UNIT_W:0]              new_end,
  output logic                             hit,
  output logic     [PTR_W-1:0]             hit_idx,
  output logic     [UNIT_W-1:0]            uni_start,
  output logic     [UNIT_W:0]              uni_end
);
  logic [PTR_W-1:0]  idx;
  logic [UNIT_W-1:0] lo;
  logic [UNIT_W:0]   hi;

  // Search starts one past the offered slot, so the offered and sent
  // entries are never candidates.
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    uni_start = new_start;
    uni_end   = new_end;
    idx       = iss_ptr;
    lo        = new_start;
    hi        = new_end;
    for (int k = 1; k < DEPTH; k++) begin
      idx = iss_ptr + PTR_W'(k);
      lo  = (slot_start[idx] < new_start) ? slot_start[idx] : new_start;
      hi  = (slot_end[idx] > new_end) ? slot_end[idx] : new_end;
      if (!hit && slot_st[idx] == SL_PEND && slot_page[idx] == new_page &&
          {1'b0, new_start} <= slot_end[idx] &&
          {1'b0, slot_start[idx]} <= new_end &&
          (hi - {1'b0, lo}) <= (UNIT_W+1)'(MERGE_MAX)) begin
        hit       = 1'b1;
        hit_idx   = idx;
        uni_start = lo;
        uni_end   = hi;
      end
    end
  end

  // R3: a merged range always covers the need it absorbs
  always_comb begin
    if (hit) begin
      a_r3_covers_need: assert (uni_start <= new_start && uni_end >= new_end);
    end
  end
endmodule

// File: rtl/mcq_cpl_match.sv
module mcq_cpl_match
  import mcq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PAGE_W = 4,
  parameter int UNIT_W = 5,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  slot_st_e [DEPTH-1:0]             slot_st,
  input  logic     [DEPTH-1:0][PAGE_W-1:0] slot_page,
  input  logic     [DEPTH-1:0][UNIT_W-1:0] slot_start,
  input  logic     [DEPTH-1:0][UNIT_W:0]   slot_end,
  input  logic     [PTR_W-1:0]             head_ptr,
  input  logic     [PAGE_W-1:0]            cpl_page,
  input  logic     [UNIT_W-1:0]            cpl_start,
  input  logic     [UNIT_W:0]              cpl_len,
  output logic                             hit,
  output logic     [PTR_W-1:0]             hit_idx
);
  logic [UNIT_W:0]  cpl_end;
  logic [PTR_W-1:0] idx;

  always_comb begin
    cpl_end = (UNIT_W+1)'(cpl_start) + cpl_len;
    hit     = 1'b0;
    hit_idx = '0;
    idx     = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PTR_W'(k);
      if (!hit && slot_st[idx] == SL_SENT && slot_page[idx] == cpl_page &&
          slot_start[idx] == cpl_start && slot_end[idx] == cpl_end) begin
        hit     = 1'b1;
        hit_idx = idx;
      end
    end
  end
endmodule

// File: rtl/migration_coalesce_queue.sv
module migration_coalesce_queue
  import mcq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int PAGE_W    = 4,
  parameter int UNIT_W    = 5,
  parameter int MIN_LEN   = 4,
  parameter int MERGE_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need_valid,
  output logic              need_ready,
  input  logic [PAGE_W-1:0] need_page,
  input  logic [UNIT_W-1:0] need_start,
  input  logic [UNIT_W:0]   need_count,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PAGE_W-1:0] req_page,
  output logic [UNIT_W-1:0] req_start,
  output logic [UNIT_W:0]   req_len,
  input  logic              cpl_valid,
  input  logic [PAGE_W-1:0] cpl_page,
  input  logic [UNIT_W-1:0] cpl_start,
  input  logic [UNIT_W:0]   cpl_len,
  output logic              replay_valid,
  output logic [PAGE_W-1:0] replay_page
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int UNITS = 1 << UNIT_W;
  localparam logic [UNIT_W-1:0] GRAIN_MASK = UNIT_W'(MIN_LEN - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  slot_st_e [DEPTH-1:0]             st_q, st_d;
  logic     [DEPTH-1:0][PAGE_W-1:0] pg_q, pg_d;
  logic     [DEPTH-1:0][UNIT_W-1:0] bs_q, bs_d;
  logic     [DEPTH-1:0][UNIT_W:0]   be_q, be_d;
  logic     [DEPTH-1:0]             slot_we;
  logic     [PTR_W-1:0]             head_q, head_d, tail_q, tail_d, iss_q, iss_d;
  logic                             rep_v_q, rep_v_d;
  logic     [PAGE_W-1:0]            rep_pg_q, rep_pg_d;

  // widened need
  logic [UNIT_W-1:0] w_start;
  logic [UNIT_W:0]   w_end;
  mcq_widen #(.UNIT_W(UNIT_W), .MIN_LEN(MIN_LEN)) u_widen (
    .in_start (need_start),
    .in_count (need_count),
    .out_start(w_start),
    .out_end  (w_end)
  );

  logic              mrg_hit;
  logic [PTR_W-1:0]  mrg_idx;
  logic [UNIT_W-1:0] mrg_start;
  logic [UNIT_W:0]   mrg_end;
  mcq_merge_find #(
    .DEPTH(DEPTH), .PAGE_W(PAGE_W), .UNIT_W(UNIT_W), .MERGE_MAX(MERGE_MAX)
  ) u_merge (
    .slot_st   (st_q),
    .slot_page (pg_q),
    .slot_start(bs_q),
    .slot_end  (be_q),
    .iss_ptr   (iss_q),
    .new_page  (need_page),
    .new_start (w_start),
    .new_end   (w_end),
    .hit       (mrg_hit),
    .hit_idx   (mrg_idx),
    .uni_start (mrg_start),
    .uni_end   (mrg_end)
  );

  logic             cpl_hit;
  logic [PTR_W-1:0] cpl_idx;
  mcq_cpl_match #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .UNIT_W(UNIT_W)) u_cpl (
    .slot_st   (st_q),
    .slot_page (pg_q),
    .slot_start(bs_q),
    .slot_end  (be_q),
    .head_ptr  (head_q),
    .cpl_page  (cpl_page),
    .cpl_start (cpl_start),
    .cpl_len   (cpl_len),
    .hit       (cpl_hit),
    .hit_idx   (cpl_idx)
  );

  logic need_fire, req_fire, head_retire;

  assign need_ready  = mrg_hit || (st_q[tail_q] == SL_FREE);
  assign req_valid   = (st_q[iss_q] == SL_PEND);
  assign req_page    = pg_q[iss_q];
  assign req_start   = bs_q[iss_q];
  assign req_len     = be_q[iss_q] - {1'b0, bs_q[iss_q]};
  assign need_fire   = need_valid && need_ready;
  assign req_fire    = req_valid && req_ready;
  assign head_retire = (st_q[head_q] == SL_DONE);
  assign replay_valid = rep_v_q;
  assign replay_page  = rep_pg_q;

  // next state: all writes in one cycle touch distinct slots
  always_comb begin
    st_d     = st_q;
    pg_d     = pg_q;
    bs_d     = bs_q;
    be_d     = be_q;
    slot_we  = '0;
    head_d   = head_q;
    tail_d   = tail_q;
    iss_d    = iss_q;
    rep_v_d  = 1'b0;
    rep_pg_d = rep_pg_q;
    if (need_fire) begin
      if (mrg_hit) begin
        slot_we[mrg_idx] = 1'b1;
        bs_d[mrg_idx]    = mrg_start;
        be_d[mrg_idx]    = mrg_end;
      end else begin
        slot_we[tail_q] = 1'b1;
        st_d[tail_q]    = SL_PEND;
        pg_d[tail_q]    = need_page;
        bs_d[tail_q]    = w_start;
        be_d[tail_q]    = w_end;
        tail_d          = tail_q + 1'b1;
      end
    end
    if (req_fire) begin
      st_d[iss_q] = SL_SENT;
      iss_d       = iss_q + 1'b1;
    end
    if (cpl_valid && cpl_hit) begin
      st_d[cpl_idx] = SL_DONE;
      rep_v_d       = 1'b1;
      rep_pg_d      = cpl_page;
    end
    if (head_retire) begin
      st_d[head_q] = SL_FREE;
      head_d       = head_q + 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SL_FREE;
      head_q   <= '0;
      tail_q   <= '0;
      iss_q    <= '0;
      rep_v_q  <= 1'b0;
      rep_pg_q <= '0;
    end else begin
      st_q    <= st_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      iss_q   <= iss_d;
      rep_v_q <= rep_v_d;
      if (rep_v_d) rep_pg_q <= rep_pg_d;
    end
  end

  // range storage: no reset, written only under its slot enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) begin
        pg_q[i] <= pg_d[i];
        bs_q[i] <= bs_d[i];
        be_q[i] <= be_d[i];
      end
    end
  end

  // assertions
  a_r2_len_floor: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> req_len >= (UNIT_W+1)'(MIN_LEN));

  a_r2_in_page: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> ({1'b0, req_start} + {1'b0, req_len}) <= (UNIT_W+2)'(UNITS));

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |-> (req_start & GRAIN_MASK) == '0);

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_page) && $stable(req_start) && $stable(req_len)));

  a_r7_replay_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    replay_valid |-> $past(cpl_valid));

  a_r7_replay_page: assert property (@(posedge clk) disable iff (!rst_sync_n)
    replay_valid |-> replay_page == $past(cpl_page));
endmodule

// File: tb/tb_migration_coalesce_queue.sv
`timescale 1ns/1ps
module tb_migration_coalesce_queue;
  localparam int D    = 8;
  localparam int PW   = 4;
  localparam int UW   = 5;
  localparam int MINL = 4;
  localparam int MM   = 8;
  localparam int UNITS = 1 << UW;

  logic clk;
  logic rst_n;
  logic need_valid, need_ready;
  logic [PW-1:0] need_page;
  logic [UW-1:0] need_start;
  logic [UW:0]   need_count;
  logic req_valid, req_ready;
  logic [PW-1:0] req_page;
  logic [UW-1:0] req_start;
  logic [UW:0]   req_len;
  logic cpl_valid;
  logic [PW-1:0] cpl_page;
  logic [UW-1:0] cpl_start;
  logic [UW:0]   cpl_len;
  logic replay_valid;
  logic [PW-1:0] replay_page;

  migration_coalesce_queue #(
    .DEPTH(D), .PAGE_W(PW), .UNIT_W(UW), .MIN_LEN(MINL), .MERGE_MAX(MM)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .need_valid(need_valid), .need_ready(need_ready), .need_page(need_page),
    .need_start(need_start), .need_count(need_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .req_start(req_start), .req_len(req_len),
    .cpl_valid(cpl_valid), .cpl_page(cpl_page), .cpl_start(cpl_start),
    .cpl_len(cpl_len),
    .replay_valid(replay_valid), .replay_page(replay_page)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference queue: 0 free, 1 pending, 2 sent, 3 done
  int m_st[D];
  int m_pg[D];
  int m_s[D];
  int m_e[D];
  int m_head, m_tail, m_iss;
  int m_rep_v, m_rep_pg;

  // issue log
  int log_pg[64];
  int log_s[64];
  int log_l[64];
  int log_n = 0;

  int obs_nr, obs_rv, obs_rep;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void widen(input int st, input int cnt, output int ws, output int we);
    ws = st - (st % MINL);
    we = st + cnt;
    if (we > UNITS) we = UNITS;
    if (we < ws + MINL) we = ws + MINL;
  endfunction

  function automatic void mfind(input int np, input int ns, input int ne,
                                output bit hit, output int hidx, output int us, output int ue);
    hit = 0; hidx = 0; us = ns; ue = ne;
    for (int k = 1; k < D; k++) begin
      int ix, lo, hi;
      ix = (m_iss + k) % D;
      lo = (m_s[ix] < ns) ? m_s[ix] : ns;
      hi = (m_e[ix] > ne) ? m_e[ix] : ne;
      if (!hit && m_st[ix] == 1 && m_pg[ix] == np && ns <= m_e[ix] &&
          m_s[ix] <= ne && (hi - lo) <= MM) begin
        hit = 1; hidx = ix; us = lo; ue = hi;
      end
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < D; i++) begin
      m_st[i] = 0; m_pg[i] = 0; m_s[i] = 0; m_e[i] = 0;
    end
    m_head = 0; m_tail = 0; m_iss = 0; m_rep_v = 0; m_rep_pg = 0;
  endfunction

  // one clock cycle: drive, compare, advance the reference
  task automatic cyc(input bit nv, input int np, input int ns, input int nc,
                     input bit rr, input bit cv, input int cp, input int cs, input int cl);
    bit hit, rv, nr, retire, chit;
    int hidx, us, ue, ws, we, cidx;
    @(negedge clk);
    need_valid = nv; need_page = PW'(np); need_start = UW'(ns); need_count = (UW+1)'(nc);
    req_ready = rr;
    cpl_valid = cv; cpl_page = PW'(cp); cpl_start = UW'(cs); cpl_len = (UW+1)'(cl);
    #1;
    widen(ns, nc, ws, we);
    mfind(np, ws, we, hit, hidx, us, ue);
    rv = (m_st[m_iss] == 1);
    nr = hit || (m_st[m_tail] == 0);
    obs_nr = int'(need_ready); obs_rv = int'(req_valid); obs_rep = int'(replay_valid);
    chk("R6 need_ready", int'(need_ready), int'(nr));
    chk("R5/R8 req_valid", int'(req_valid), int'(rv));
    if (rv && req_valid) begin
      chk("R1/R3/R5 req_page", int'(req_page), m_pg[m_iss]);
      chk("R1/R3/R5 req_start", int'(req_start), m_s[m_iss]);
      chk("R1/R3/R5 req_len", int'(req_len), m_e[m_iss] - m_s[m_iss]);
      chk("R2 len floor", int'(req_len >= MINL), 1);
      chk("R2 aligned", int'(req_start) % MINL, 0);
      chk("R2 in page", int'(int'(req_start) + int'(req_len) <= UNITS), 1);
    end
    chk("R7 replay_valid", int'(replay_valid), m_rep_v);
    if (m_rep_v == 1) chk("R7 replay_page", int'(replay_page), m_rep_pg);
    // advance reference
    retire = (m_st[m_head] == 3);
    if (nv && nr) begin
      if (hit) begin
        m_s[hidx] = us; m_e[hidx] = ue;
      end else begin
        m_st[m_tail] = 1; m_pg[m_tail] = np; m_s[m_tail] = ws; m_e[m_tail] = we;
        m_tail = (m_tail + 1) % D;
      end
    end
    if (rv && rr) begin
      if (log_n < 64) begin
        log_pg[log_n] = m_pg[m_iss]; log_s[log_n] = m_s[m_iss];
        log_l[log_n] = m_e[m_iss] - m_s[m_iss];
        log_n++;
      end
      m_st[m_iss] = 2;
      m_iss = (m_iss + 1) % D;
    end
    chit = 0; cidx = 0;
    if (cv) begin
      for (int k = 0; k < D; k++) begin
        int ix;
        ix = (m_head + k) % D;
        if (!chit && m_st[ix] == 2 && m_pg[ix] == cp && m_s[ix] == cs &&
            m_e[ix] == cs + cl) begin
          chit = 1; cidx = ix;
        end
      end
    end
    m_rep_v = 0;
    if (chit) begin
      m_st[cidx] = 3; m_rep_v = 1; m_rep_pg = cp;
    end
    if (retire) begin
      m_st[m_head] = 0;
      m_head = (m_head + 1) % D;
    end
  endtask

  task automatic idle(input bit rr);
    cyc(0, 0, 0, 1, rr, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int g = 0; g < 80; g++) begin
      bit any, found;
      int cp, cs, cl;
      any = 0; found = 0; cp = 0; cs = 0; cl = 0;
      for (int i = 0; i < D; i++) begin
        if (m_st[i] != 0) any = 1;
        if (!found && m_st[i] == 2) begin
          found = 1; cp = m_pg[i]; cs = m_s[i]; cl = m_e[i] - m_s[i];
        end
      end
      if (!any) break;
      cyc(0, 0, 0, 1, 1, found, cp, cs, cl);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    need_valid = 0; need_page = '0; need_start = '0; need_count = '0;
    req_ready = 0; cpl_valid = 0; cpl_page = '0; cpl_start = '0; cpl_len = '0;
    rst_n = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R9: reset state
    @(negedge clk); #1;
    chk("R9 need_ready after reset", int'(need_ready), 1);
    chk("R9 req_valid after reset", int'(req_valid), 0);
    chk("R9 replay_valid after reset", int'(replay_valid), 0);

    // R1, R3, R8: build up with the link stalled
    cyc(1, 2, 0, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 5, 1, 0, 0, 0, 0, 0);
    chk("R8 offered one cycle after handshake", obs_rv, 1);
    cyc(1, 1, 9, 2, 0, 0, 0, 0, 0);
    cyc(1, 1, 14, 1, 0, 0, 0, 0, 0);
    cyc(1, 3, 30, 8, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) idle(1);
    chk("R5 order count", log_n, 4);
    chk("R5 first page", log_pg[0], 2);
    chk("R1 widened length", log_l[0], 4);
    chk("R3 merged page", log_pg[1], 1);
    chk("R3 merged start", log_s[1], 4);
    chk("R3 merged length", log_l[1], 8);
    chk("R3 over-limit not merged start", log_s[2], 12);
    chk("R3 over-limit not merged length", log_l[2], 4);
    chk("R1 clipped start", log_s[3], 28);
    chk("R1 clipped length", log_l[3], 4);

    // R4: adjacent to a sent entry, must be appended separately
    cyc(1, 1, 12, 1, 1, 0, 0, 0, 0);
    idle(1);
    chk("R4 separate request start", log_s[4], 12);
    chk("R4 separate request length", log_l[4], 4);

    // R7: matching and unmatched completions
    cyc(0, 0, 0, 1, 1, 1, 2, 0, 4);
    idle(1);
    chk("R7 replay after match", obs_rep, 1);
    cyc(0, 0, 0, 1, 1, 1, 5, 1, 3);
    idle(1);
    chk("R7 no replay when unmatched", obs_rep, 0);

    drain();

    // R6: fill the queue with the link stalled
    for (int p = 0; p < D; p++) cyc(1, p, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 9, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 full and unmergeable blocks", obs_nr, 0);
    cyc(1, 1, 4, 1, 0, 0, 0, 0, 0);
    chk("R6 full but mergeable accepted", obs_nr, 1);
    cyc(0, 0, 4, 1, 0, 0, 0, 0, 0);
    chk("R4 offered entry not a merge target", obs_nr, 0);
    drain();

    // random traffic
    for (int t = 0; t < 4000; t++) begin
      bit nv, rr, cv;
      int np, ns, nc, cp, cs, cl, nsent, pick;
      nv = ($urandom % 3) != 0;
      np = $urandom % 4;
      ns = $urandom % UNITS;
      nc = 1 + ($urandom % 12);
      rr = ($urandom % 4) != 0;
      cv = 0; cp = 0; cs = 0; cl = 0;
      nsent = 0;
      for (int i = 0; i < D; i++) if (m_st[i] == 2) nsent++;
      if (nsent > 0 && ($urandom % 3) == 0) begin
        pick = $urandom % nsent;
        for (int i = 0; i < D; i++) begin
          if (m_st[i] == 2) begin
            if (pick == 0) begin
              cv = 1; cp = m_pg[i]; cs = m_s[i]; cl = m_e[i] - m_s[i];
            end
            pick--;
          end
        end
      end else if (($urandom % 16) == 0) begin
        cv = 1; cp = $urandom % 4; cs = 1; cl = 3;
      end
      cyc(nv, np, ns, nc, rr, cv, cp, cs, cl);
    end
    drain();

    done = 1;
    summary();
    $finish;
  end
endmodule